// File: doc/BRIEF.md
# Programmable Asynchronous Memory Strobe Sequencer

This block drives the control pins of an asynchronous parallel or NAND-style memory for one access at a time. A one-clock start pulse carries a read/write flag, a command flag, a chip-select index and a 16-bit write word. Together with it comes a set of 5-bit timing fields that place every strobe edge at a count of ticks from the start of the access. The block then plays the access out. Each of chip select, write enable, output enable and the address-latch strobe is asserted (low) on the ticks from its on-time up to, but not including, its off-time. A command-latch strobe, a driven data bus and a final done pulse complete the access.

A tick is one functional-clock period, or two when the granularity bit is set. Each of the four main strobes has its own extra-delay bit. When that bit is set, the strobe is taken from a copy retimed on the falling clock edge, which moves both of its edges half a clock later. All timing fields, flags and data are captured when the access is accepted and held until it finishes. A start that arrives while an access is running is dropped.

Top module: `amseq_strobe_seq`

## Requirements
- R1: After reset, all six chip selects, write enable, output enable and the address strobe are high, the command-latch strobe is low, the data-bus enable and the data bus are zero, and done is low.
- R2: In a write, the write enable is low exactly on ticks t with we_on <= t < we_off. Ticks are counted from 0 at the start of the access. The pin level for tick t is visible from 1 + t*G clocks after the clock edge that accepts start, where G is 1, or 2 when gran is set. The write enable never goes low in a read.
- R3: Only the chip select numbered cs_sel goes low, on ticks cs_on <= t < off. Here off is cs_wr_off in a write and cs_rd_off in a read. The other chip selects stay high, and a cs_sel value of 6 or 7 drives none of them low.
- R4: In both reads and writes, the address strobe is low on ticks adv_on <= t < adv_off.
- R5: In a read, the output enable is low on ticks oe_on <= t < oe_off. It never goes low in a write.
- R6: An access lasts L ticks, where L is wr_len for a write or rd_len for a read, and a value of 0 counts as 1. Done is high for exactly one clock, 1 + (L*G - 1) clocks after the accepting edge, which is the last clock of the access.
- R7: When gran is set, every tick lasts two clocks, so every strobe edge and the done pulse land at twice the clock count they would have with gran clear.
- R8: Each of xd_cs, xd_we, xd_oe and xd_adv, when set, delays both edges of its strobe by half a clock. With xd_we set, the data-bus enable is delayed by the same half clock.
- R9: In a write, the data-bus enable is high and the bus carries the captured write word on ticks 0 to L-1. Outside those ticks the enable is low and the bus is zero. The bus is never driven in a read.
- R10: In a write with cmd set, the command-latch strobe is high on ticks 0 to L-1. Otherwise it stays low.
- R11: A start that arrives while an access is running is ignored. The running access keeps its captured fields, flags and data to the end.
- R12: If a strobe's off-time is not greater than its on-time, or is greater than L, that strobe stays high for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Access request pulse |
| rd | input | 1 | 1 = read access, 0 = write access |
| cmd | input | 1 | Write is a command cycle (raises command-latch strobe) |
| cs_sel | input | 3 | Chip-select index, 0 to 5 valid |
| wdata | input | 16 | Write word |
| cs_on | input | 5 | Chip-select assert tick |
| cs_wr_off | input | 5 | Chip-select release tick, write |
| cs_rd_off | input | 5 | Chip-select release tick, read |
| we_on | input | 5 | Write-enable assert tick |
| we_off | input | 5 | Write-enable release tick |
| oe_on | input | 5 | Output-enable assert tick |
| oe_off | input | 5 | Output-enable release tick |
| adv_on | input | 5 | Address-strobe assert tick |
| adv_off | input | 5 | Address-strobe release tick |
| wr_len | input | 5 | Write access length in ticks |
| rd_len | input | 5 | Read access length in ticks |
| gran | input | 1 | Two clocks per tick when set |
| xd_cs | input | 1 | Half-clock delay for chip select |
| xd_we | input | 1 | Half-clock delay for write enable and data |
| xd_oe | input | 1 | Half-clock delay for output enable |
| xd_adv | input | 1 | Half-clock delay for address strobe |
| mem_cs_n | output | 6 | Active-low chip selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_adv_n | output | 1 | Active-low address strobe |
| mem_cle | output | 1 | Command-latch strobe, active high |
| mem_ad_oe | output | 1 | Data-bus drive enable |
| mem_ad | output | 16 | Data bus value |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
The hardest effects to expose at the ports are the half-clock shifts. A strobe taken from the falling-edge copy matches the plain copy when both are observed at a rising edge one cycle apart. The bench therefore samples 1 ns after each rising edge, where a delayed strobe still shows the previous clock's level. It compares that against a model that indexes the delayed strobe one clock earlier. A start that lands in the middle of a running access is produced by pulsing start, with a different index, direction and data word, in the middle of a scripted access. The bench then checks every remaining clock of the first access against that access's own expected waveform.

// File: rtl/amseq_pkg.sv
package amseq_pkg;
  localparam int unsigned TW = 5;
  typedef logic [TW-1:0] tick_t;

  typedef struct packed {
    tick_t cs_on;
    tick_t cs_wr_off;
    tick_t cs_rd_off;
    tick_t we_on;
    tick_t we_off;
    tick_t oe_on;
    tick_t oe_off;
    tick_t adv_on;
    tick_t adv_off;
    tick_t wr_len;
    tick_t rd_len;
    logic  gran;
    logic  xd_cs;
    logic  xd_we;
    logic  xd_oe;
    logic  xd_adv;
  } tcfg_t;

  // A programmed length of zero is treated as one tick.
  function automatic tick_t eff_len(input tick_t len);
    return (len == '0) ? tick_t'(1) : len;
  endfunction

  // A window is usable only if it opens before it closes and closes inside the access.
  function automatic logic win_ok(input tick_t on_t, input tick_t off_t, input tick_t len);
    return (off_t > on_t) && (off_t <= len);
  endfunction

  function automatic logic in_win(input tick_t on_t, input tick_t off_t,
                                  input tick_t len, input tick_t t);
    return win_ok(on_t, off_t, len) && (t >= on_t) && (t < off_t);
  endfunction
endpackage

// File: rtl/amseq_ticker.sv
module amseq_ticker #(
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          gran,
  input  logic [TW-1:0] len,
  output logic          busy,
  output logic [TW-1:0] tick,
  output logic          sub,
  output logic          last_clk
);
  logic last_tick;
  logic sub_done;

  assign last_tick = (tick == len - TW'(1));
  assign sub_done  = (sub == gran);
  assign last_clk  = busy && last_tick && sub_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tick <= '0;
      sub  <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
      tick <= '0;
      sub  <= 1'b0;
    end else if (busy) begin
      if (sub_done) begin
        sub <= 1'b0;
        if (last_tick) begin
          busy <= 1'b0;
          tick <= '0;
        end else begin
          tick <= tick + TW'(1);
        end
      end else begin
        sub <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/amseq_strobe.sv
module amseq_strobe #(
  parameter int unsigned W       = 1,
  parameter bit          ACT_LOW = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] act,
  input  logic         xd,
  output logic [W-1:0] pin,
  output logic [W-1:0] pin_rise
);
  localparam logic [W-1:0] IDLE = {W{ACT_LOW}};

  logic [W-1:0] fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_rise <= IDLE;
    else        pin_rise <= act ^ IDLE;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= IDLE;
    else        fall_q <= pin_rise;
  end

  assign pin = xd ? fall_q : pin_rise;
endmodule

// File: rtl/amseq_strobe_seq.sv
module amseq_strobe_seq
  import amseq_pkg::*;
#(
  parameter int unsigned NCS  = 6,
  parameter int unsigned DW   = 16,
  parameter int unsigned SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rd,
  input  logic            cmd,
  input  logic [SELW-1:0] cs_sel,
  input  logic [DW-1:0]   wdata,
  input  logic [4:0]      cs_on,
  input  logic [4:0]      cs_wr_off,
  input  logic [4:0]      cs_rd_off,
  input  logic [4:0]      we_on,
  input  logic [4:0]      we_off,
  input  logic [4:0]      oe_on,
  input  logic [4:0]      oe_off,
  input  logic [4:0]      adv_on,
  input  logic [4:0]      adv_off,
  input  logic [4:0]      wr_len,
  input  logic [4:0]      rd_len,
  input  logic            gran,
  input  logic            xd_cs,
  input  logic            xd_we,
  input  logic            xd_oe,
  input  logic            xd_adv,
  output logic [NCS-1:0]  mem_cs_n,
  output logic            mem_we_n,
  output logic            mem_oe_n,
  output logic            mem_adv_n,
  output logic            mem_cle,
  output logic            mem_ad_oe,
  output logic [DW-1:0]   mem_ad,
  output logic            done
);
  // Captured access
  tcfg_t           cfg_q;
  logic            rd_q;
  logic            cmd_q;
  logic [SELW-1:0] sel_q;
  logic [DW-1:0]   wdata_q;

  // Sequencer state, named for the checker
  logic          busy;
  logic [TW-1:0] tick;
  logic          sub;
  logic          last_clk;
  logic          accept;
  tick_t         len;
  tick_t         cs_off_sel;

  // Per-strobe requests (active high) in tick time
  logic [NCS-1:0] cs_act;
  logic           cs_any;
  logic           we_act;
  logic           oe_act;
  logic           adv_act;
  logic           cle_act;
  logic           bus_act;

  // Rising-edge copies of each pin
  logic [NCS-1:0] cs_rise;
  logic           we_rise;
  logic           oe_rise;
  logic           adv_rise;
  logic           cle_rise;
  logic           bus_rise;

  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rd_q    <= 1'b0;
      cmd_q   <= 1'b0;
      sel_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      cfg_q.cs_on     <= cs_on;
      cfg_q.cs_wr_off <= cs_wr_off;
      cfg_q.cs_rd_off <= cs_rd_off;
      cfg_q.we_on     <= we_on;
      cfg_q.we_off    <= we_off;
      cfg_q.oe_on     <= oe_on;
      cfg_q.oe_off    <= oe_off;
      cfg_q.adv_on    <= adv_on;
      cfg_q.adv_off   <= adv_off;
      cfg_q.wr_len    <= wr_len;
      cfg_q.rd_len    <= rd_len;
      cfg_q.gran      <= gran;
      cfg_q.xd_cs     <= xd_cs;
      cfg_q.xd_we     <= xd_we;
      cfg_q.xd_oe     <= xd_oe;
      cfg_q.xd_adv    <= xd_adv;
      rd_q    <= rd;
      cmd_q   <= cmd && !rd;
      sel_q   <= cs_sel;
      wdata_q <= wdata;
    end
  end

  assign len        = rd_q ? eff_len(cfg_q.rd_len) : eff_len(cfg_q.wr_len);
  assign cs_off_sel = rd_q ? cfg_q.cs_rd_off : cfg_q.cs_wr_off;

  amseq_ticker #(.TW(TW)) u_ticker (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .gran     (cfg_q.gran),
    .len      (len),
    .busy     (busy),
    .tick     (tick),
    .sub      (sub),
    .last_clk (last_clk)
  );

  // Window decode
  assign cs_any  = busy && in_win(cfg_q.cs_on, cs_off_sel, len, tick);
  assign we_act  = busy && !rd_q && in_win(cfg_q.we_on, cfg_q.we_off, len, tick);
  assign oe_act  = busy && rd_q && in_win(cfg_q.oe_on, cfg_q.oe_off, len, tick);
  assign adv_act = busy && in_win(cfg_q.adv_on, cfg_q.adv_off, len, tick);
  assign cle_act = busy && cmd_q;
  assign bus_act = busy && !rd_q;

  for (genvar gi = 0; gi < NCS; gi++) begin : g_cs_dec
    assign cs_act[gi] = cs_any && (sel_q == SELW'(gi));
  end

  // Strobe drivers
  amseq_strobe #(.W(NCS), .ACT_LOW(1'b1)) u_cs (
    .clk(clk), .rst_n(rst_n), .act(cs_act), .xd(cfg_q.xd_cs),
    .pin(mem_cs_n), .pin_rise(cs_rise)
  );

  amseq_strobe #(.W(1), .ACT_LOW(1'b1)) u_we (
    .clk(clk), .rst_n(rst_n), .act(we_act), .xd(cfg_q.xd_we),
    .pin(mem_we_n), .pin_rise(we_rise)
  );

  amseq_strobe #(.W(1), .ACT_LOW(1'b1)) u_oe (
    .clk(clk), .rst_n(rst_n), .act(oe_act), .xd(cfg_q.xd_oe),
    .pin(mem_oe_n), .pin_rise(oe_rise)
  );

  amseq_strobe #(.W(1), .ACT_LOW(1'b1)) u_adv (
    .clk(clk), .rst_n(rst_n), .act(adv_act), .xd(cfg_q.xd_adv),
    .pin(mem_adv_n), .pin_rise(adv_rise)
  );

  amseq_strobe #(.W(1), .ACT_LOW(1'b0)) u_cle (
    .clk(clk), .rst_n(rst_n), .act(cle_act), .xd(1'b0),
    .pin(mem_cle), .pin_rise(cle_rise)
  );

  // Data enable follows the write-enable retiming so data outlives the strobe
  amseq_strobe #(.W(1), .ACT_LOW(1'b0)) u_bus (
    .clk(clk), .rst_n(rst_n), .act(bus_act), .xd(cfg_q.xd_we),
    .pin(mem_ad_oe), .pin_rise(bus_rise)
  );

  assign mem_ad = {DW{mem_ad_oe}} & wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= last_clk;
  end
endmodule

// File: rtl/amseq_checker.sv
module amseq_checker
  import amseq_pkg::*;
#(
  parameter int unsigned NCS = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           sub,
  input logic           start,
  input tcfg_t          cfg_q,
  input logic [NCS-1:0] mem_cs_n,
  input logic           mem_we_n,
  input logic           mem_oe_n,
  input logic           mem_cle,
  input logic           mem_ad_oe,
  input logic           done
);
  a_r3_one_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);

  a_r5_no_we_oe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  a_r9_data_covers_we: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_ad_oe);

  a_r9_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ad_oe);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_sub_needs_gran: assert property (@(posedge clk) disable iff (!rst_n)
    sub |-> cfg_q.gran);

  a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cfg_q));

  a_r10_cle_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cle |-> mem_oe_n);
endmodule

bind amseq_strobe_seq amseq_checker #(.NCS(NCS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .sub       (sub),
  .start     (start),
  .cfg_q     (cfg_q),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_cle   (mem_cle),
  .mem_ad_oe (mem_ad_oe),
  .done      (done)
);

// File: tb/amseq_strobe_seq_bench.sv
`timescale 1ns/1ps
module amseq_strobe_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0, cmd = 1'b0;
  logic [2:0] cs_sel = '0;
  logic [15:0] wdata = '0;
  logic [4:0] cs_on = '0, cs_wr_off = '0, cs_rd_off = '0, we_on = '0, we_off = '0;
  logic [4:0] oe_on = '0, oe_off = '0, adv_on = '0, adv_off = '0, wr_len = '0, rd_len = '0;
  logic gran = 1'b0, xd_cs = 1'b0, xd_we = 1'b0, xd_oe = 1'b0, xd_adv = 1'b0;
  logic [5:0] mem_cs_n;
  logic mem_we_n, mem_oe_n, mem_adv_n, mem_cle, mem_ad_oe, done;
  logic [15:0] mem_ad;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  amseq_strobe_seq u_amseq_strobe_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rd(rd), .cmd(cmd), .cs_sel(cs_sel),
    .wdata(wdata), .cs_on(cs_on), .cs_wr_off(cs_wr_off), .cs_rd_off(cs_rd_off),
    .we_on(we_on), .we_off(we_off), .oe_on(oe_on), .oe_off(oe_off),
    .adv_on(adv_on), .adv_off(adv_off), .wr_len(wr_len), .rd_len(rd_len),
    .gran(gran), .xd_cs(xd_cs), .xd_we(xd_we), .xd_oe(xd_oe), .xd_adv(xd_adv),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_adv_n(mem_adv_n), .mem_cle(mem_cle), .mem_ad_oe(mem_ad_oe),
    .mem_ad(mem_ad), .done(done)
  );

  // Tick index seen m clocks after the accepting edge, or -1 outside the access.
  function automatic int tick_at(int m, int l, int g);
    if (m < 1 || (m - 1) >= l * g) return -1;
    return (m - 1) / g;
  endfunction

  function automatic bit lowat(int on_t, int off_t, int l, int g, int m);
    int t;
    t = tick_at(m, l, g);
    if (t < 0) return 1'b0;
    if (!(off_t > on_t && off_t <= l)) return 1'b0;
    return (t >= on_t) && (t < off_t);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Run one access and compare every pin on every clock against the model.
  // inject_m >= 0 pulses a conflicting start after sample inject_m.
  task automatic run_access(string req, bit r, bit c, int sel, logic [15:0] d, int inject_m);
    int l, g, n;
    bit r_q, c_q;
    logic [15:0] d_q;
    int sel_q;
    int cso, cswo, csro, weo, weoff, oeo, oeoff, advo, advoff;
    bit xc, xw, xo, xa;
    l = r ? ((rd_len == 0) ? 1 : int'(rd_len)) : ((wr_len == 0) ? 1 : int'(wr_len));
    g = gran ? 2 : 1;
    n = l * g + 3;
    r_q = r; c_q = c && !r; d_q = d; sel_q = sel;
    cso = cs_on; cswo = cs_wr_off; csro = cs_rd_off; weo = we_on; weoff = we_off;
    oeo = oe_on; oeoff = oe_off; advo = adv_on; advoff = adv_off;
    xc = xd_cs; xw = xd_we; xo = xd_oe; xa = xd_adv;
    @(negedge clk);
    rd = r; cmd = c; cs_sel = 3'(sel); wdata = d; start = 1'b1;
    @(posedge clk);
    #1;
    for (int m = 0; m <= n; m++) begin
      logic [5:0] e_cs;
      bit e_we, e_oe, e_adv, e_cle, e_bus, e_done;
      int mc, mw, mo, ma;
      if (m > 0) begin
        @(posedge clk);
        #1;
      end
      if (m == 0 || m == inject_m + 1) start = 1'b0;
      mc = xc ? m - 1 : m;
      mw = xw ? m - 1 : m;
      mo = xo ? m - 1 : m;
      ma = xa ? m - 1 : m;
      e_cs = 6'h3f;
      if (sel_q < 6 && lowat(cso, r_q ? csro : cswo, l, g, mc)) e_cs[sel_q] = 1'b0;
      e_we   = !r_q && lowat(weo, weoff, l, g, mw);
      e_oe   = r_q && lowat(oeo, oeoff, l, g, mo);
      e_adv  = lowat(advo, advoff, l, g, ma);
      e_cle  = c_q && tick_at(m, l, g) >= 0;
      e_bus  = !r_q && tick_at(mw, l, g) >= 0;
      e_done = (m == l * g);
      check(req, {mem_cs_n, !mem_we_n, !mem_oe_n, !mem_adv_n, mem_cle, mem_ad_oe, done, mem_ad},
                 {e_cs, e_we, e_oe, e_adv, e_cle, e_bus, e_done, e_bus ? d_q : 16'h0});
      if (m == inject_m) begin
        rd = !r; cmd = 1'b1; cs_sel = 3'((sel + 1) % 6); wdata = ~d; start = 1'b1;
      end
    end
    @(negedge clk);
  endtask

  task automatic set_base();
    cs_on = 0; cs_wr_off = 12; cs_rd_off = 10; we_on = 3; we_off = 8;
    oe_on = 2; oe_off = 7; adv_on = 1; adv_off = 3; wr_len = 12; rd_len = 10;
    gran = 0; xd_cs = 0; xd_we = 0; xd_oe = 0; xd_adv = 0;
  endtask

  task automatic t_reset();
    check("R1 reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_adv_n, mem_cle, mem_ad_oe, done, mem_ad},
                      {6'h3f, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0});
  endtask

  task automatic t_write();
    set_base();
    run_access("R2 R3 R4 R9 write", 1'b0, 1'b0, 2, 16'hA5C3, -1);
    cs_on = 1; we_on = 0; we_off = 12; adv_on = 0; adv_off = 1;
    run_access("R2 R3 full-width write", 1'b0, 1'b0, 5, 16'h1234, -1);
  endtask

  task automatic t_read();
    set_base();
    run_access("R5 R3 R4 read", 1'b1, 1'b0, 0, 16'hFFFF, -1);
  endtask

  task automatic t_gran();
    set_base(); gran = 1;
    run_access("R7 write doubled", 1'b0, 1'b0, 3, 16'h0F0F, -1);
    run_access("R7 read doubled", 1'b1, 1'b0, 4, 16'h0, -1);
  endtask

  task automatic t_half();
    set_base(); xd_cs = 1; xd_we = 1; xd_oe = 1; xd_adv = 1; we_off = 12;
    run_access("R8 write half-delay", 1'b0, 1'b0, 1, 16'h5A5A, -1);
    run_access("R8 read half-delay", 1'b1, 1'b0, 1, 16'h0, -1);
    xd_cs = 0; xd_oe = 0; gran = 1;
    run_access("R8 mixed half-delay doubled", 1'b0, 1'b0, 0, 16'hC0DE, -1);
  endtask

  task automatic t_cmd();
    set_base(); wr_len = 4; cs_wr_off = 4; we_on = 1; we_off = 3; adv_off = 2;
    run_access("R10 command write", 1'b0, 1'b1, 0, 16'h0070, -1);
    run_access("R10 command flag in read", 1'b1, 1'b1, 0, 16'h0, -1);
  endtask

  task automatic t_clamp();
    set_base(); we_on = 5; we_off = 5; adv_off = 20; cs_wr_off = 13;
    run_access("R12 clamp write", 1'b0, 1'b0, 2, 16'hBEEF, -1);
    oe_on = 6; oe_off = 4;
    run_access("R12 clamp read", 1'b1, 1'b0, 2, 16'h0, -1);
  endtask

  task automatic t_edges();
    set_base();
    run_access("R3 index out of range", 1'b0, 1'b0, 7, 16'h7777, -1);
    wr_len = 0; cs_wr_off = 1; we_on = 0; we_off = 1; adv_on = 0; adv_off = 1;
    run_access("R6 zero length", 1'b0, 1'b0, 4, 16'h8001, -1);
    set_base(); wr_len = 31; cs_wr_off = 31; we_off = 30;
    run_access("R6 longest write", 1'b0, 1'b0, 5, 16'h4321, -1);
  endtask

  task automatic t_busy();
    set_base();
    run_access("R11 start while busy", 1'b0, 1'b0, 2, 16'h3C3C, 4);
    gran = 1;
    run_access("R11 start while busy doubled", 1'b1, 1'b0, 3, 16'h0, 7);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_write();
    t_read();
    t_gran();
    t_half();
    t_cmd();
    t_clamp();
    t_edges();
    t_busy();
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule